// File: doc/BRIEF.md
# CRC-4 Interworking and Remote Alarm Controller

This block drives the transmitted Remote Alarm Indication (RAI) bit of a 2.048 Mbit/s framer. It also decides what happens to CRC-4 processing when the far end never shows CRC-4 multiframe alignment. A reframe strobe with no multiframe alignment starts a hunt. During the hunt every reframe raises RAI for one frame period, and a millisecond timer runs. If alignment is still missing when the hunt interval ends, the outcome depends on the interworking control. With interworking enabled, the block gives up: it stops the search, disables CRC checking, keeps RAI low and flags that the link runs without CRC-4. With interworking disabled, it keeps searching and holds RAI high until alignment is found or CRC synchronisation drops.

An override control forces RAI to a software-chosen level in every state, without touching the state machine. The multiframe search itself is outside this block. The search consumes `searchEn` and `crcProcEn` and reports back through `mfFound` and `crcSync`.

Top module: `crc4iw_top`

## Requirements
- R1: While reset is asserted (asynchronous, active low) and after it is released, txRai=0, searchEn=1, crcProcEn=1 and nonCrcInd=0.
- R2: In idle, a reframeStb cycle with mfFound=0 starts a hunt. txRai goes to 1 after that clock edge and stays 1 until the first later clock edge that sees frameStb=1.
- R3: During a hunt, each further reframeStb produces another one-frame RAI pulse. Millisecond ticks advance the hunt timer without changing txRai.
- R4: With autoIwOff=0, the TIMEOUT_MS-th msTick of a hunt (counted from the hunt start) ends it: searchEn=0, crcProcEn=0, nonCrcInd=1 and txRai=0 from that edge on.
- R5: With autoIwOff=1, the TIMEOUT_MS-th msTick ends the hunt in an alarm state: txRai=1 continuously, searchEn=1 and crcProcEn=1.
- R6: With autoIwOff=1, a falling crcSync (1 in one cycle, 0 in the next) during a hunt or alarm terminates the search. searchEn=0, crcProcEn=1 and txRai=0 hold until mfFound=1 returns the block to idle.
- R7: mfFound=1 during a hunt, alarm or terminated state returns the block to idle. A later hunt needs the full TIMEOUT_MS ticks again.
- R8: With alarmOvr=1, txRai equals alarmVal in the same cycle, whatever the state. The state and the other outputs are unaffected.
- R9: With alarmOvr=0, alarmVal has no effect on txRai.
- R10: nonCrcInd stays set through reframe and mfFound activity. It clears only on reset or when autoIwOff changes, and that change also returns the block to idle.
- R11: A reframeStb cycle with mfFound=1 in idle starts no hunt and causes no RAI pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| autoIwOff | input | 1 | 1 disables automatic CRC-to-non-CRC interworking |
| alarmOvr | input | 1 | 1 forces txRai to alarmVal |
| alarmVal | input | 1 | Forced RAI level when alarmOvr=1 |
| reframeStb | input | 1 | One-cycle strobe for each basic-frame reframe event |
| frameStb | input | 1 | One-cycle strobe once per frame period |
| mfFound | input | 1 | CRC-4 multiframe alignment present |
| crcSync | input | 1 | CRC synchronisation flag from the search logic |
| msTick | input | 1 | One-cycle strobe each millisecond |
| txRai | output | 1 | RAI bit to transmit |
| searchEn | output | 1 | Multiframe search may continue |
| crcProcEn | output | 1 | CRC-4 checking enabled |
| nonCrcInd | output | 1 | Link has fallen back to non-CRC operation |

## Verification
The bench builds the block with TIMEOUT_MS=6 instead of 400. Both hunt outcomes, a timer restart after an aborted hunt, and the terminate path therefore fit in a short vector table. At that size the exact tick that ends a hunt (the sixth, not the fifth) can be checked cycle by cycle, and the same holds under each interworking setting. The override and sticky-flag cases are run in the final states that only a completed hunt reaches.

// File: rtl/crc4iw_pkg.sv
package crc4iw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_IW_DONE,
    ST_ALARM,
    ST_TERM
  } iwState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic timerClr;
    logic timerEn;
    logic flickArm;
  } dpCmd_t;

endpackage

// File: rtl/crc4iw_datapath.sv
module crc4iw_datapath
  import crc4iw_pkg::*;
#(
  parameter int TIMEOUT_MS = 400
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCmd_t cmd,
  input  logic   msTick,
  input  logic   frameStb,
  input  logic   crcSync,
  input  logic   autoIwOff,
  output logic   timerDone,
  output logic   flickOn,
  output logic   syncFell,
  output logic   modeChg
);

  localparam int CW = (TIMEOUT_MS > 1) ? $clog2(TIMEOUT_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_MS - 1);

  logic [CW-1:0] msCnt;
  logic          syncQ;
  logic          autcQ;

  // hunt interval timer, counted in millisecond ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msCnt <= '0;
    end else if (cmd.timerClr) begin
      msCnt <= '0;
    end else if (cmd.timerEn && msTick && (msCnt != LAST)) begin
      msCnt <= msCnt + 1'b1;
    end
  end

  assign timerDone = cmd.timerEn && msTick && (msCnt == LAST);

  // one-frame RAI pulse; a new arm wins over the clearing strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flickOn <= 1'b0;
    end else if (cmd.flickArm) begin
      flickOn <= 1'b1;
    end else if (frameStb) begin
      flickOn <= 1'b0;
    end
  end

  // edge detection on sync flag and mode control
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= 1'b0;
      autcQ <= 1'b0;
    end else begin
      syncQ <= crcSync;
      autcQ <= autoIwOff;
    end
  end

  assign syncFell = syncQ && !crcSync;
  assign modeChg  = autcQ != autoIwOff;

endmodule

// File: rtl/crc4iw_ctrl.sv
module crc4iw_ctrl
  import crc4iw_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   autoIwOff,
  input  logic   alarmOvr,
  input  logic   alarmVal,
  input  logic   reframeStb,
  input  logic   mfFound,
  input  logic   timerDone,
  input  logic   flickOn,
  input  logic   syncFell,
  input  logic   modeChg,
  output dpCmd_t cmd,
  output logic   txRai,
  output logic   searchEn,
  output logic   crcProcEn,
  output logic   nonCrcInd
);

  iwState_e state, stateNxt;
  logic     nonCrcNxt;
  logic     raiNat;

  always_comb begin
    stateNxt     = state;
    nonCrcNxt    = nonCrcInd;
    cmd          = '0;
    cmd.timerEn  = (state == ST_HUNT);
    if (modeChg) begin
      stateNxt     = ST_IDLE;
      nonCrcNxt    = 1'b0;
      cmd.timerClr = 1'b1;
      cmd.timerEn  = 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reframeStb && !mfFound) begin
            stateNxt     = ST_HUNT;
            cmd.timerClr = 1'b1;
            cmd.flickArm = 1'b1;
          end
        end
        ST_HUNT: begin
          if (mfFound) begin
            stateNxt = ST_IDLE;
          end else if (autoIwOff && syncFell) begin
            stateNxt = ST_TERM;
          end else if (timerDone) begin
            if (autoIwOff) begin
              stateNxt = ST_ALARM;
            end else begin
              stateNxt  = ST_IW_DONE;
              nonCrcNxt = 1'b1;
            end
          end else if (reframeStb) begin
            cmd.flickArm = 1'b1;
          end
        end
        ST_ALARM: begin
          if (mfFound) begin
            stateNxt = ST_IDLE;
          end else if (syncFell) begin
            stateNxt = ST_TERM;
          end
        end
        ST_TERM: begin
          if (mfFound) begin
            stateNxt = ST_IDLE;
          end
        end
        ST_IW_DONE: stateNxt = ST_IW_DONE;
        default:    stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      nonCrcInd <= 1'b0;
    end else begin
      state     <= stateNxt;
      nonCrcInd <= nonCrcNxt;
    end
  end

  always_comb begin
    raiNat = 1'b0;
    if (state == ST_ALARM) begin
      raiNat = 1'b1;
    end else if (state == ST_HUNT) begin
      raiNat = flickOn;
    end
  end

  assign txRai     = alarmOvr ? alarmVal : raiNat;
  assign searchEn  = (state != ST_IW_DONE) && (state != ST_TERM);
  assign crcProcEn = (state != ST_IW_DONE);

endmodule

// File: rtl/crc4iw_top.sv
module crc4iw_top
  import crc4iw_pkg::*;
#(
  parameter int TIMEOUT_MS = 400
) (
  input  logic clk,
  input  logic rstN,
  input  logic autoIwOff,
  input  logic alarmOvr,
  input  logic alarmVal,
  input  logic reframeStb,
  input  logic frameStb,
  input  logic mfFound,
  input  logic crcSync,
  input  logic msTick,
  output logic txRai,
  output logic searchEn,
  output logic crcProcEn,
  output logic nonCrcInd
);

  dpCmd_t cmd;
  logic   timerDone;
  logic   flickOn;
  logic   syncFell;
  logic   modeChg;

  crc4iw_datapath #(.TIMEOUT_MS(TIMEOUT_MS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .msTick    (msTick),
    .frameStb  (frameStb),
    .crcSync   (crcSync),
    .autoIwOff (autoIwOff),
    .timerDone (timerDone),
    .flickOn   (flickOn),
    .syncFell  (syncFell),
    .modeChg   (modeChg)
  );

  crc4iw_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .autoIwOff  (autoIwOff),
    .alarmOvr   (alarmOvr),
    .alarmVal   (alarmVal),
    .reframeStb (reframeStb),
    .mfFound    (mfFound),
    .timerDone  (timerDone),
    .flickOn    (flickOn),
    .syncFell   (syncFell),
    .modeChg    (modeChg),
    .cmd        (cmd),
    .txRai      (txRai),
    .searchEn   (searchEn),
    .crcProcEn  (crcProcEn),
    .nonCrcInd  (nonCrcInd)
  );

endmodule

// File: rtl/crc4iw_checks.sv
module crc4iw_checks (
  input logic clk,
  input logic rstN,
  input logic autoIwOff,
  input logic alarmOvr,
  input logic alarmVal,
  input logic reframeStb,
  input logic frameStb,
  input logic mfFound,
  input logic crcSync,
  input logic msTick,
  input logic txRai,
  input logic searchEn,
  input logic crcProcEn,
  input logic nonCrcInd
);

  AST_NONCRC_QUIET_LINK: assert property (@(posedge clk) disable iff (!rstN)
    nonCrcInd |-> (!searchEn && !crcProcEn)); // R4

  AST_NONCRC_RAI_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (nonCrcInd && !alarmOvr) |-> !txRai); // R4

  AST_CRC_OFF_NO_SEARCH: assert property (@(posedge clk) disable iff (!rstN)
    !crcProcEn |-> !searchEn); // R4

  AST_TERM_RAI_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!searchEn && crcProcEn && !alarmOvr) |-> !txRai); // R6

  AST_NONCRC_CLEAR_ON_MODE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nonCrcInd) |-> ($past(autoIwOff) != $past(autoIwOff, 2))); // R10

endmodule

bind crc4iw_top crc4iw_checks u_chk (.*);

// File: tb/tb_crc4iw_top.sv
module tb_crc4iw_top;

  localparam int TMO = 6;
  localparam int NV  = 42;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic autoIwOff = 1'b0, alarmOvr = 1'b0, alarmVal = 1'b0;
  logic reframeStb = 1'b0, frameStb = 1'b0, mfFound = 1'b0;
  logic crcSync = 1'b0, msTick = 1'b0;
  logic txRai, searchEn, crcProcEn, nonCrcInd;

  int nRun = 0;
  int nFail = 0;

  crc4iw_top #(.TIMEOUT_MS(TMO)) dut (
    .clk(clk), .rstN(rstN), .autoIwOff(autoIwOff), .alarmOvr(alarmOvr),
    .alarmVal(alarmVal), .reframeStb(reframeStb), .frameStb(frameStb),
    .mfFound(mfFound), .crcSync(crcSync), .msTick(msTick),
    .txRai(txRai), .searchEn(searchEn), .crcProcEn(crcProcEn),
    .nonCrcInd(nonCrcInd)
  );

  always #2 clk = ~clk;

  // layout: {autoIwOff, alarmOvr, alarmVal, crcSync,
  //          frameStb, msTick, mfFound, reframeStb,
  //          expRai, expSearch, expProc, expNonCrc}
  localparam logic [11:0] VEC [NV] = '{
    12'b0000_0000_0110, 12'b0000_0001_1110, 12'b0000_1000_0110,
    12'b0000_0100_0110, 12'b0000_0001_1110, 12'b0000_1100_0110,
    12'b0000_0100_0110, 12'b0000_0100_0110, 12'b0000_0100_0110,
    12'b0000_0100_0001, 12'b0000_0011_0001, 12'b0010_0000_0001,
    12'b0110_0000_1001, 12'b1000_0000_0110, 12'b1000_0001_1110,
    12'b1000_1100_0110, 12'b1000_0100_0110, 12'b1000_0100_0110,
    12'b1000_0100_0110, 12'b1000_0100_0110, 12'b1000_0100_1110,
    12'b1100_1000_0110, 12'b1000_0000_1110, 12'b1000_0010_0110,
    12'b1000_0001_1110, 12'b1000_1100_0110, 12'b1000_0100_0110,
    12'b1000_0100_0110, 12'b1000_0010_0110, 12'b1000_0001_1110,
    12'b1000_1100_0110, 12'b1000_0100_0110, 12'b1000_0100_0110,
    12'b1000_0100_0110, 12'b1000_0100_0110, 12'b1000_0100_1110,
    12'b1001_0000_1110, 12'b1000_0000_0010, 12'b1000_0001_0010,
    12'b1000_0010_0110, 12'b1000_0011_0110, 12'b1000_0000_0110
  };

  function automatic string reqOf(int idx);
    if (idx == 0) return "R1";
    if (idx <= 2 || idx == 14) return "R2";
    if (idx <= 8) return "R3";
    if (idx == 9) return "R4";
    if (idx == 10 || idx == 13) return "R10";
    if (idx == 11) return "R9";
    if (idx == 12 || idx == 21) return "R8";
    if (idx <= 22) return "R5";
    if (idx <= 35) return "R7";
    if (idx <= 39) return "R6";
    return "R11";
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: {rai,search,proc,nonCrc} actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {txRai, searchEn, crcProcEn, nonCrcInd};
  endfunction

  task automatic idleInputs();
    reframeStb = 1'b0; frameStb = 1'b0; mfFound = 1'b0;
    msTick = 1'b0; crcSync = 1'b0; alarmOvr = 1'b0; alarmVal = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", outs(), 4'b0110);
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {autoIwOff, alarmOvr, alarmVal, crcSync,
       frameStb, msTick, mfFound, reframeStb} = VEC[i][11:4];
      @(posedge clk);
      #1 check(reqOf(i), outs(), VEC[i][3:0]);
    end

    // R2: pulse held while no frame strobe arrives
    @(negedge clk); idleInputs(); autoIwOff = 1'b0;
    @(negedge clk); reframeStb = 1'b1;
    @(negedge clk); reframeStb = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R2", outs(), 4'b1110);

    // R1: asynchronous reset mid-hunt
    @(negedge clk); rstN = 1'b0;
    #1 check("R1", outs(), 4'b0110);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk);
    #1 check("R1", outs(), 4'b0110);

    // R4: exact tick count after reset, fifth tick must not end the hunt
    @(negedge clk); reframeStb = 1'b1;
    @(negedge clk); reframeStb = 1'b0; frameStb = 1'b1;
    @(negedge clk); frameStb = 1'b0;
    for (int t = 0; t < TMO - 1; t++) begin
      @(negedge clk); msTick = 1'b1;
    end
    @(negedge clk); msTick = 1'b0;
    #1 check("R4", outs(), 4'b0110);
    @(negedge clk); msTick = 1'b1;
    @(posedge clk);
    #1 check("R4", outs(), 4'b0001);
    @(negedge clk); msTick = 1'b0;

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule